// File: doc/BRIEF.md
# Working Register File with Single-Level Shadow Set

This block holds the sixteen 16-bit working registers of a processor core. Two combinational read ports and one write port serve the datapath. Each read port returns the value its register will hold after the coming clock edge, so a result written this cycle is already visible. The write port takes either a full word or only the least significant byte. The highest register, W15, is the stack pointer. Its bit 0 is always zero, and a dedicated adjust port moves it up or down by two for calls, returns and exception entry.

A single-level shadow set backs up W0 to W3 and five status flags, which arrive on `flags_in`. A push command copies all of them in one cycle. A pop command writes the saved words back into W0 to W3 in one cycle, and for that cycle it presents the saved flags on `flags_restore` with `flags_load` high, so that the status register outside this block can reload them.

A two-state controller tracks whether the shadow set is filled:
- `SH_EMPTY` moves to `SH_FULL` on a push that comes without a pop.
- `SH_FULL` stays in `SH_FULL` on another push without a pop, and the new contents overwrite the old ones.
- `SH_FULL` moves to `SH_EMPTY` on any pop.
- A pop in `SH_EMPTY` is not effective.

Top module: `wreg_file`

## Requirements
- R1: After reset, registers W0 to W14 read 0x0000 and W15 reads 0x0800. The shadow set is empty and `flags_load` is low.
- R2: A word write (`wr_en`=1, `wr_byte`=0) stores `wr_data` into register `wr_addr`. Both read ports return the written value in the same cycle and in every later cycle until the register changes again.
- R3: A byte write (`wr_en`=1, `wr_byte`=1) replaces only bits 7:0 of the target register with `wr_data[7:0]`. Bits 15:8 keep their previous value.
- R4: Bit 0 of W15 is stored and read as 0 for every kind of update. For example, a word write of 0xFFFF to W15 reads back 0xFFFE.
- R5: `sp_inc` alone adds 2 to W15 and `sp_dec` alone subtracts 2, both modulo 2^16 (0xFFFE plus 2 gives 0x0000). If both are high, W15 keeps its value.
- R6: While `sp_inc` or `sp_dec` is high, a normal write addressed to W15 is discarded and the adjust result is stored.
- R7: A push (`shd_push`=1, `shd_pop`=0) copies the contents of W0 to W3 as they stood before the edge, together with `flags_in`, into the shadow set. A second push overwrites the first.
- R8: A pop in state `SH_FULL` loads the saved words into W0 to W3 at the edge. In that same cycle it raises `flags_load` and drives the saved flags on `flags_restore`, and the shadow set becomes empty.
- R9: When an effective pop and a normal write target the same register among W0 to W3 in the same cycle, the restored shadow value is stored.
- R10: A pop in state `SH_EMPTY` has no effect: `flags_load` stays low and W0 to W3 change only through the normal write. A push together with a pop is dropped.
- R11: The shadow contents are unreachable through the read ports, which return only working registers. `flags_restore` is 0 whenever `flags_load` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ra_addr | input | 4 | Read port A register index |
| ra_data | output | 16 | Read port A data, forwarded |
| rb_addr | input | 4 | Read port B register index |
| rb_data | output | 16 | Read port B data, forwarded |
| wr_en | input | 1 | Write enable |
| wr_byte | input | 1 | 1 = low byte only, 0 = full word |
| wr_addr | input | 4 | Write register index |
| wr_data | input | 16 | Write data |
| sp_inc | input | 1 | Add 2 to W15 |
| sp_dec | input | 1 | Subtract 2 from W15 |
| shd_push | input | 1 | Copy W0-W3 and flags into the shadow set |
| shd_pop | input | 1 | Restore W0-W3 and flags from the shadow set |
| flags_in | input | 5 | Current status flags to save |
| flags_restore | output | 5 | Saved flags, valid while flags_load is high |
| flags_load | output | 1 | High in the cycle of an effective pop |

## Verification
The bench builds the block with its defaults: sixteen 16-bit registers, four shadowed words, five flags, a stack reset value of 0x0800 and a step of two. With a 16-bit stack pointer, the wrap from 0xFFFE to 0x0000 takes a single write followed by one increment. With only four shadowed words, a random stream of writes, pushes and pops quickly produces the collisions between pop and write, pushes into a full shadow set and pops from an empty one. A behavioural model predicts both read ports and the flag outputs in every cycle.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
    typedef enum logic {
        SH_EMPTY = 1'b0,
        SH_FULL  = 1'b1
    } sh_state_e;
endpackage

// File: rtl/wrf_sp.sv
// Stack pointer adjust: +STEP / -STEP, alignment bit kept clear.
module wrf_sp #(
    parameter int DATA_W = 16,
    parameter int STEP   = 2
) (
    input  logic [DATA_W-1:0] cur,
    input  logic              inc,
    input  logic              dec,
    output logic              upd,
    output logic [DATA_W-1:0] nxt
);
    localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

    logic [DATA_W-1:0] sum;

    always_comb begin
        sum = cur;
        if (inc) sum = sum + STEP_V;
        if (dec) sum = sum - STEP_V;
        nxt = {sum[DATA_W-1:1], 1'b0};
        upd = inc | dec;
    end
endmodule

// File: rtl/wrf_shadow.sv
// Single-level shadow set with its fill-state controller.
module wrf_shadow
    import wrf_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int SHADOW_CNT = 4,
    parameter int FLAG_W     = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic [SHADOW_CNT*DATA_W-1:0] live_w,
    input  logic [FLAG_W-1:0]            flags_in,
    output logic                         pop_eff,
    output logic [SHADOW_CNT*DATA_W-1:0] saved_w,
    output logic [FLAG_W-1:0]            flags_restore
);
    sh_state_e         state_q, state_d;
    logic              push_eff;
    logic [FLAG_W-1:0] flags_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SH_EMPTY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_EMPTY: if (push && !pop) state_d = SH_FULL;
            SH_FULL:  if (pop)          state_d = SH_EMPTY;
            default:                    state_d = SH_EMPTY;
        endcase
    end

    // outputs of the controller
    always_comb begin
        pop_eff  = 1'b0;
        push_eff = 1'b0;
        unique case (state_q)
            SH_EMPTY: push_eff = push && !pop;
            SH_FULL: begin
                pop_eff  = pop;
                push_eff = push && !pop;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            saved_w <= '0;
            flags_q <= '0;
        end else if (push_eff) begin
            saved_w <= live_w;
            flags_q <= flags_in;
        end
    end

    assign flags_restore = pop_eff ? flags_q : '0;

    p_push_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (state_q == SH_FULL));

    p_pop_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_eff |=> (state_q == SH_EMPTY));

    p_empty_no_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_EMPTY) |-> !pop_eff);

    p_push_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (saved_w == $past(live_w)) && (flags_q == $past(flags_in)));
endmodule

// File: rtl/wreg_file.sv
module wreg_file #(
    parameter int              NUM_REGS   = 16,
    parameter int              DATA_W     = 16,
    parameter int              SHADOW_CNT = 4,
    parameter int              FLAG_W     = 5,
    parameter logic [15:0]     SP_RESET   = 16'h0800,
    parameter int              SP_STEP    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(NUM_REGS)-1:0] ra_addr,
    output logic [DATA_W-1:0]           ra_data,
    input  logic [$clog2(NUM_REGS)-1:0] rb_addr,
    output logic [DATA_W-1:0]           rb_data,
    input  logic                        wr_en,
    input  logic                        wr_byte,
    input  logic [$clog2(NUM_REGS)-1:0] wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        sp_inc,
    input  logic                        sp_dec,
    input  logic                        shd_push,
    input  logic                        shd_pop,
    input  logic [FLAG_W-1:0]           flags_in,
    output logic [FLAG_W-1:0]           flags_restore,
    output logic                        flags_load
);
    localparam int AW     = $clog2(NUM_REGS);
    localparam int SP_IDX = NUM_REGS - 1;
    localparam int BYTE_W = 8;

    logic [DATA_W-1:0]            regs_q [NUM_REGS];
    logic [DATA_W-1:0]            nxt    [NUM_REGS];
    logic [SHADOW_CNT*DATA_W-1:0] live_flat;
    logic [SHADOW_CNT*DATA_W-1:0] saved_flat;
    logic                         pop_eff;
    logic                         sp_upd;
    logic [DATA_W-1:0]            sp_nxt;
    logic [DATA_W-1:0]            wr_merged;
    logic [DATA_W-1:0]            wr_cur;

    assign wr_cur    = regs_q[wr_addr];
    assign wr_merged = wr_byte ? {wr_cur[DATA_W-1:BYTE_W], wr_data[BYTE_W-1:0]} : wr_data;

    wrf_sp #(
        .DATA_W (DATA_W),
        .STEP   (SP_STEP)
    ) u_sp (
        .cur (regs_q[SP_IDX]),
        .inc (sp_inc),
        .dec (sp_dec),
        .upd (sp_upd),
        .nxt (sp_nxt)
    );

    wrf_shadow #(
        .DATA_W     (DATA_W),
        .SHADOW_CNT (SHADOW_CNT),
        .FLAG_W     (FLAG_W)
    ) u_shadow (
        .clk           (clk),
        .rst_n         (rst_n),
        .push          (shd_push),
        .pop           (shd_pop),
        .live_w        (live_flat),
        .flags_in      (flags_in),
        .pop_eff       (pop_eff),
        .saved_w       (saved_flat),
        .flags_restore (flags_restore)
    );

    assign flags_load = pop_eff;

    // Next value of each register, by priority: pop > SP adjust > write.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic hit;
        assign hit = wr_en && (wr_addr == AW'(i));
        if (i == SP_IDX) begin : g_sp
            always_comb begin
                if (sp_upd)   nxt[i] = sp_nxt;
                else if (hit) nxt[i] = {wr_merged[DATA_W-1:1], 1'b0};
                else          nxt[i] = regs_q[i];
            end
        end else if (i < SHADOW_CNT) begin : g_shd
            assign live_flat[i*DATA_W +: DATA_W] = regs_q[i];
            always_comb begin
                if (pop_eff)  nxt[i] = saved_flat[i*DATA_W +: DATA_W];
                else if (hit) nxt[i] = wr_merged;
                else          nxt[i] = regs_q[i];
            end
        end else begin : g_plain
            always_comb nxt[i] = hit ? wr_merged : regs_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_REGS; k++)
                regs_q[k] <= (k == SP_IDX) ? DATA_W'(SP_RESET) : '0;
        end else begin
            for (int k = 0; k < NUM_REGS; k++)
                regs_q[k] <= nxt[k];
        end
    end

    assign ra_data = nxt[ra_addr];
    assign rb_data = nxt[rb_addr];

    p_sp_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q[SP_IDX][0] == 1'b0);

    p_sp_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_inc && !sp_dec) |=> regs_q[SP_IDX] == $past(regs_q[SP_IDX]) + DATA_W'(SP_STEP));

    p_sp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_inc && sp_dec) |=> $stable(regs_q[SP_IDX]));

    p_sp_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_dec && !sp_inc && wr_en && wr_addr == AW'(SP_IDX))
            |=> regs_q[SP_IDX] == $past(regs_q[SP_IDX]) - DATA_W'(SP_STEP));

    p_byte_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_byte && wr_addr != AW'(SP_IDX) && !(pop_eff && wr_addr < AW'(SHADOW_CNT)))
            |=> regs_q[$past(wr_addr)][DATA_W-1:BYTE_W] == $past(wr_cur[DATA_W-1:BYTE_W]));

    p_flags_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_load |-> (flags_restore == '0));
endmodule

// File: tb/sim_wreg_file.sv
module sim_wreg_file;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ra_addr = '0, rb_addr = '0, wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        wr_en = 1'b0, wr_byte = 1'b0, sp_inc = 1'b0, sp_dec = 1'b0;
    logic        shd_push = 1'b0, shd_pop = 1'b0;
    logic [4:0]  flags_in = '0;
    logic [15:0] ra_data, rb_data;
    logic [4:0]  flags_restore;
    logic        flags_load;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    logic [15:0] m_reg [16];
    logic [15:0] m_sh  [4];
    logic [4:0]  m_shf;
    bit          m_full;

    always #(CLK_PERIOD/2) clk = ~clk;

    wreg_file u0 (
        .clk(clk), .rst_n(rst_n),
        .ra_addr(ra_addr), .ra_data(ra_data),
        .rb_addr(rb_addr), .rb_data(rb_data),
        .wr_en(wr_en), .wr_byte(wr_byte), .wr_addr(wr_addr), .wr_data(wr_data),
        .sp_inc(sp_inc), .sp_dec(sp_dec),
        .shd_push(shd_push), .shd_pop(shd_pop),
        .flags_in(flags_in), .flags_restore(flags_restore), .flags_load(flags_load)
    );

    function automatic logic [15:0] model_next(int idx);
        logic [15:0] v;
        bit pe;
        pe = shd_pop && m_full;
        v = m_reg[idx];
        if (wr_en && int'(wr_addr) == idx)
            v = wr_byte ? {m_reg[idx][15:8], wr_data[7:0]} : wr_data;
        if (idx == 15) begin
            if (sp_inc || sp_dec) begin
                v = m_reg[15];
                if (sp_inc) v = v + 16'd2;
                if (sp_dec) v = v - 16'd2;
            end
            v[0] = 1'b0;
        end
        if (idx < 4 && pe) v = m_sh[idx];
        return v;
    endfunction

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one cycle: inputs already driven after a falling edge
    task automatic step(string tag);
        logic [15:0] nx [16];
        bit pe, pu;
        #1;
        for (int i = 0; i < 16; i++) nx[i] = model_next(i);
        pe = shd_pop && m_full;
        pu = shd_push && !shd_pop;
        check(tag, "ra_data", ra_data, nx[ra_addr]);
        check(tag, "rb_data", rb_data, nx[rb_addr]);
        check(tag, "flags_load", {15'd0, flags_load}, {15'd0, pe});
        check(tag, "flags_restore", {11'd0, flags_restore}, pe ? {11'd0, m_shf} : 16'd0);
        @(posedge clk);
        if (pu) begin
            for (int i = 0; i < 4; i++) m_sh[i] = m_reg[i];
            m_shf = flags_in;
            m_full = 1'b1;
        end
        if (pe) m_full = 1'b0;
        for (int i = 0; i < 16; i++) m_reg[i] = nx[i];
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; wr_byte = 0; sp_inc = 0; sp_dec = 0;
        shd_push = 0; shd_pop = 0;
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d, logic b);
        wr_en = 1; wr_addr = a; wr_data = d; wr_byte = b;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < 16; i++) m_reg[i] = (i == 15) ? 16'h0800 : 16'h0000;
        for (int i = 0; i < 4; i++) m_sh[i] = '0;
        m_shf = '0;
        m_full = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state on all addresses
        for (int a = 0; a < 8; a++) begin
            ra_addr = 4'(a); rb_addr = 4'(a + 8);
            step("R1");
        end

        // R2 word write, forwarded then held
        ra_addr = 5; rb_addr = 5;
        wr(5, 16'h1234, 0); step("R2");
        idle(); step("R2");
        // R3 byte write
        wr(5, 16'hABCD, 1); step("R3");
        idle(); step("R3");
        // R4 SP alignment, word and byte
        ra_addr = 15; rb_addr = 15;
        wr(15, 16'hFFFF, 0); step("R4");
        wr(15, 16'h0033, 1); step("R4");
        // R5 adjust and wrap
        idle(); wr(15, 16'hFFFE, 0); step("R5");
        idle(); sp_inc = 1; step("R5");
        sp_inc = 0; sp_dec = 1; step("R5");
        sp_inc = 1; step("R5");
        idle(); step("R5");
        // R6 adjust beats write to W15
        wr(15, 16'h4444, 0); sp_inc = 1; step("R6");
        sp_inc = 0; sp_dec = 1; step("R6");
        idle();
        // R7 push, then overwrite with a second push
        ra_addr = 0; rb_addr = 3;
        for (int i = 0; i < 4; i++) begin wr(4'(i), 16'h1000 + 16'(i), 0); step("R7"); end
        idle(); flags_in = 5'h15; shd_push = 1; wr(0, 16'hDEAD, 0); step("R7");
        idle(); wr(3, 16'h3333, 0); flags_in = 5'h0A; shd_push = 1; step("R7");
        idle(); wr(0, 16'h0BAD, 0); step("R7");
        // R8 pop restores words and flags
        idle(); shd_pop = 1; step("R8");
        idle(); step("R8");
        // R10 pop when empty; push with pop dropped
        wr(1, 16'h7777, 0); shd_pop = 1; ra_addr = 1; step("R10");
        idle(); shd_push = 1; shd_pop = 1; step("R10");
        idle(); shd_pop = 1; step("R10");
        // R9 pop beats write to a shadowed register
        idle(); flags_in = 5'h1F; shd_push = 1; step("R9");
        idle(); wr(2, 16'h9999, 0); ra_addr = 2; step("R9");
        idle(); wr(2, 16'h5555, 1); shd_pop = 1; step("R9");
        idle(); step("R9");
        // R11 reads show working registers only; flags quiet
        shd_push = 1; step("R11");
        idle();
        for (int a = 0; a < 16; a++) begin
            ra_addr = 4'(a); rb_addr = 4'(15 - a); step("R11");
        end

        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            wr_en    = ($urandom_range(0, 1) == 1);
            wr_byte  = ($urandom_range(0, 2) == 0);
            wr_addr  = 4'($urandom_range(0, 15));
            wr_data  = 16'($urandom);
            sp_inc   = ($urandom_range(0, 5) == 0);
            sp_dec   = ($urandom_range(0, 5) == 0);
            shd_push = ($urandom_range(0, 6) == 0);
            shd_pop  = ($urandom_range(0, 6) == 0);
            flags_in = 5'($urandom);
            ra_addr  = ($urandom_range(0, 1) == 1) ? wr_addr : 4'($urandom_range(0, 15));
            rb_addr  = 4'($urandom_range(0, 15));
            step("R2");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule